// File: doc/BRIEF.md
# SPI Pin-Control and Mode-Fault Unit

This block is a byte-wide SPI controller that can act as master or slave, wrapped in the logic that decides which of the four pins (SCK, MOSI, MISO, SS) it drives and which it only listens to. A small register bus sets the operating mode, the pin arrangement and the transmit byte, and returns the received byte. The pin control register can be written at any time, including in the middle of a transfer.

In single-wire (bidirectional) mode the block talks over one data pin: MOSI as master, MISO as slave, with a register bit that switches that pin's output buffer. As master, the SS pin can be left to other logic, used as a select output that goes low during a transfer, or watched as an input. In the last case, another device pulling SS low is a mode fault. A mode fault ends master operation at once and lets go of the bus.

In master mode, some pin-control writes abort a transfer in progress. A separate control bit halts the serial clock while the chip-level wait input is asserted.

Top module: `spi_pinctl_unit`

## Requirements
- R1: Address 0 is the mode register: bit 0 enables the unit, bit 1 selects master, bit 2 enables the select output. Address 1 is the pin register: bit 0 single-wire mode, bit 1 clock stop in wait, bit 3 single-wire output enable, bit 4 fault-detect enable. Bits 7, 6, 5 and 2 of the pin register read as 0 whatever is written. Address 2 writes the transmit byte and reads the received byte.
- R2: After reset, every register reads 0, no output enable is active, and the done and fault flags are low.
- R3: A master transfer starts when address 2 is written. It moves 8 bits MSB first with SCK idle low, samples on the rising edge and shifts on the falling edge. It then raises the done flag, clears busy and makes the received byte readable. In normal mode data comes in on MISO and MOSI is always driven.
- R4: In master single-wire mode, received data is taken from MOSI, MISO is never driven, and MOSI is driven only while pin-register bit 3 is 1.
- R5: The role of SS in master mode depends on two bits. With fault-detect 0, SS is not driven. With fault-detect 1 and select-output 0, SS is an undriven input watched for faults. With both set, SS is driven low while busy and high otherwise.
- R6: In slave mode, SCK, MOSI and SS are never driven, whatever the select bits hold. In normal mode MISO is driven while SS is low. In single-wire mode MISO is driven when pin-register bit 3 is 1.
- R7: As a slave with SS low, the unit samples MOSI on each SCK rising edge and shifts its loaded byte out on MISO MSB first. After 8 edges it raises done, and the received byte is readable.
- R8: In master mode, three pin-register writes abort a transfer in the next cycle: one that changes bit 4, one that changes bit 0, or one that changes bit 3 while bit 0 is 1. An abort leaves busy low, SCK low and done unset. Changing bit 3 while bit 0 is 0 has no effect on the transfer.
- R9: While pin-register bit 1 is 1 and the wait input is high, the master clock is frozen. With bit 1 at 0 the wait input has no effect.
- R10: As master with SS as a fault-watched input, SS sampled low sets a sticky fault flag, clears the master bit, aborts the transfer and drops the SCK and MOSI enables. A write to address 0 clears the flag. With fault-detect 0, a low SS raises no fault.
- R11: Writing address 2 clears the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| wait_i | input | 1 | Chip-level wait mode indication |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | SS pin input |
| ss_o | output | 1 | SS pin output value |
| ss_oe | output | 1 | SS output enable |
| busy | output | 1 | Master transfer in progress |
| xfer_done | output | 1 | Transfer complete flag |
| mode_fault | output | 1 | Sticky mode fault flag |

## Verification
A wrong select-role or pin-steering decode shows on the output enables in the same cycle the register is written, so every enable is checked right after each configuration change. A shift engine that fails to go idle on an abort keeps SCK toggling and busy high in the cycle after the write. A missed abort or fault appears as a late done flag or a received byte that is not the expected loopback value. A broken synchroniser or fault path shows within three cycles of SS falling, as a missing fault flag or a master bit that reads back still set.

// File: rtl/spi_pc_pkg.sv
package spi_pc_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_PIN  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic sel_out_en;
        logic master;
        logic enable;
    } mode_t;

    typedef struct packed {
        logic fault_en;
        logic wire_oe;
        logic wait_stop;
        logic single_wire;
    } pinctl_t;

    typedef enum logic [1:0] {
        SS_FREE     = 2'd0,
        SS_IN_FAULT = 2'd1,
        SS_OUT      = 2'd2,
        SS_IN_SLAVE = 2'd3
    } ss_role_e;

    function automatic mode_t unpack_mode(input logic [REG_W-1:0] d);
        mode_t m;
        m.enable     = d[0];
        m.master     = d[1];
        m.sel_out_en = d[2];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_mode(input mode_t m);
        return {{(REG_W-3){1'b0}}, m.sel_out_en, m.master, m.enable};
    endfunction

    function automatic pinctl_t unpack_pin(input logic [REG_W-1:0] d);
        pinctl_t p;
        p.single_wire = d[0];
        p.wait_stop   = d[1];
        p.wire_oe     = d[3];
        p.fault_en    = d[4];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pack_pin(input pinctl_t p);
        return {{(REG_W-5){1'b0}}, p.fault_en, p.wire_oe, 1'b0, p.wait_stop, p.single_wire};
    endfunction

    function automatic ss_role_e ss_role(input mode_t m, input pinctl_t p);
        if (!m.master)         return SS_IN_SLAVE;
        else if (!p.fault_en)  return SS_FREE;
        else if (m.sel_out_en) return SS_OUT;
        else                   return SS_IN_FAULT;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_pc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             fault_set,
    output mode_t            mode_q,
    output pinctl_t          pin_q,
    output logic             ctl_abort,
    output logic             data_wr,
    output logic             fault_q
);
    pinctl_t pin_new;
    logic    pin_wr;
    logic    mode_wr;

    assign pin_new = unpack_pin(bus_wdata);
    assign pin_wr  = bus_we && (bus_addr == ADDR_PIN);
    assign mode_wr = bus_we && (bus_addr == ADDR_MODE);
    assign data_wr = bus_we && (bus_addr == ADDR_DATA);

    always_comb begin
        ctl_abort = 1'b0;
        if (pin_wr && mode_q.master) begin
            if (pin_new.fault_en != pin_q.fault_en)       ctl_abort = 1'b1;
            if (pin_new.single_wire != pin_q.single_wire) ctl_abort = 1'b1;
            if (pin_q.single_wire && (pin_new.wire_oe != pin_q.wire_oe))
                ctl_abort = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            pin_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (pin_wr)  pin_q  <= pin_new;
            if (mode_wr) mode_q <= unpack_mode(bus_wdata);
            if (fault_set) begin
                fault_q       <= 1'b1;
                mode_q.master <= 1'b0;
            end else if (mode_wr) begin
                fault_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              master,
    input  logic              run,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              abort,
    input  logic              rx_in,
    input  logic              slave_sel,
    input  logic              sck_rise,
    input  logic              sck_fall,
    output logic              sck_out,
    output logic              tx_bit,
    output logic              busy,
    output logic              done_flag,
    output logic [DATA_W-1:0] rx_data
);
    localparam int HC_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [HC_W-1:0]   hc;
    logic [CNT_W-1:0]  bitcnt;
    logic              rx_hold;
    logic [DATA_W-1:0] shifted;
    logic              last_bit;

    assign shifted  = {shreg[DATA_W-2:0], rx_hold};
    assign last_bit = (bitcnt == CNT_W'(DATA_W - 1));
    assign tx_bit   = shreg[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            hc        <= '0;
            bitcnt    <= '0;
            rx_hold   <= 1'b0;
            sck_out   <= 1'b0;
            busy      <= 1'b0;
            done_flag <= 1'b0;
            rx_data   <= '0;
        end else begin
            if (start) done_flag <= 1'b0;
            if (abort) begin
                busy    <= 1'b0;
                sck_out <= 1'b0;
                hc      <= '0;
                bitcnt  <= '0;
            end else if (start) begin
                shreg   <= tx_data;
                bitcnt  <= '0;
                hc      <= '0;
                sck_out <= 1'b0;
                busy    <= master && enable;
            end else if (master) begin
                if (busy && run) begin
                    if (hc == HC_W'(HALF_DIV - 1)) begin
                        hc <= '0;
                        if (!sck_out) begin
                            sck_out <= 1'b1;
                            rx_hold <= rx_in;
                        end else begin
                            sck_out <= 1'b0;
                            shreg   <= shifted;
                            if (last_bit) begin
                                busy      <= 1'b0;
                                done_flag <= 1'b1;
                                rx_data   <= shifted;
                                bitcnt    <= '0;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end else begin
                        hc <= hc + 1'b1;
                    end
                end
            end else begin
                if (!slave_sel || !enable) begin
                    bitcnt <= '0;
                end else if (run) begin
                    if (sck_rise) rx_hold <= rx_in;
                    if (sck_fall) begin
                        shreg <= shifted;
                        if (last_bit) begin
                            done_flag <= 1'b1;
                            rx_data   <= shifted;
                            bitcnt    <= '0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_pin_steer.sv
module spi_pin_steer
    import spi_pc_pkg::*;
(
    input  mode_t    mode_q,
    input  pinctl_t  pin_q,
    input  ss_role_e role,
    input  logic     busy,
    input  logic     sck_int,
    input  logic     tx_bit,
    input  logic     slave_sel,
    input  logic     mosi_i,
    input  logic     miso_i,
    output logic     rx_in,
    output logic     sck_o,
    output logic     sck_oe,
    output logic     mosi_o,
    output logic     mosi_oe,
    output logic     miso_o,
    output logic     miso_oe,
    output logic     ss_o,
    output logic     ss_oe
);
    always_comb begin
        sck_o   = 1'b0;
        sck_oe  = 1'b0;
        mosi_o  = 1'b0;
        mosi_oe = 1'b0;
        miso_o  = 1'b0;
        miso_oe = 1'b0;
        ss_o    = 1'b1;
        ss_oe   = 1'b0;
        rx_in   = 1'b0;
        if (mode_q.enable) begin
            if (mode_q.master) begin
                sck_o   = sck_int;
                sck_oe  = 1'b1;
                mosi_o  = tx_bit;
                mosi_oe = pin_q.single_wire ? pin_q.wire_oe : 1'b1;
                rx_in   = pin_q.single_wire ? mosi_i : miso_i;
                if (role == SS_OUT) begin
                    ss_oe = 1'b1;
                    ss_o  = !busy;
                end
            end else begin
                miso_o  = tx_bit;
                miso_oe = pin_q.single_wire ? pin_q.wire_oe : slave_sel;
                rx_in   = pin_q.single_wire ? miso_i : mosi_i;
            end
        end
    end
endmodule

// File: rtl/spi_pinctl_unit.sv
module spi_pinctl_unit
    import spi_pc_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             wait_i,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             ss_i,
    output logic             ss_o,
    output logic             ss_oe,
    output logic             busy,
    output logic             xfer_done,
    output logic             mode_fault
);
    mode_t            mode_q;
    pinctl_t          pin_q;
    ss_role_e         role;
    logic             ctl_abort;
    logic             data_wr;
    logic             fault_set;
    logic             ss_sync;
    logic             sck_sync;
    logic             sck_prev;
    logic             sck_rise;
    logic             sck_fall;
    logic             run;
    logic             rx_in;
    logic             sck_int;
    logic             tx_bit;
    logic [REG_W-1:0] rx_data;

    spi_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst(rst), .d(ss_i), .q(ss_sync)
    );

    spi_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .d(sck_i), .q(sck_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_sync;
    end

    assign sck_rise  = sck_sync && !sck_prev;
    assign sck_fall  = !sck_sync && sck_prev;
    assign run       = !(pin_q.wait_stop && wait_i);
    assign role      = ss_role(mode_q, pin_q);
    assign fault_set = mode_q.enable && (role == SS_IN_FAULT) && !ss_sync;

    spi_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fault_set (fault_set),
        .mode_q    (mode_q),
        .pin_q     (pin_q),
        .ctl_abort (ctl_abort),
        .data_wr   (data_wr),
        .fault_q   (mode_fault)
    );

    spi_shift_engine #(.DATA_W(REG_W), .HALF_DIV(HALF_DIV)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .enable    (mode_q.enable),
        .master    (mode_q.master),
        .run       (run),
        .start     (data_wr),
        .tx_data   (bus_wdata),
        .abort     (ctl_abort || fault_set),
        .rx_in     (rx_in),
        .slave_sel (!ss_sync),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sck_out   (sck_int),
        .tx_bit    (tx_bit),
        .busy      (busy),
        .done_flag (xfer_done),
        .rx_data   (rx_data)
    );

    spi_pin_steer u_steer (
        .mode_q    (mode_q),
        .pin_q     (pin_q),
        .role      (role),
        .busy      (busy),
        .sck_int   (sck_int),
        .tx_bit    (tx_bit),
        .slave_sel (!ss_sync),
        .mosi_i    (mosi_i),
        .miso_i    (miso_i),
        .rx_in     (rx_in),
        .sck_o     (sck_o),
        .sck_oe    (sck_oe),
        .mosi_o    (mosi_o),
        .mosi_oe   (mosi_oe),
        .miso_o    (miso_o),
        .miso_oe   (miso_oe),
        .ss_o      (ss_o),
        .ss_oe     (ss_oe)
    );

    always_comb begin
        case (bus_addr)
            ADDR_MODE: bus_rdata = pack_mode(mode_q);
            ADDR_PIN:  bus_rdata = pack_pin(pin_q);
            ADDR_DATA: bus_rdata = rx_data;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_pinctl_unit_chk.sv
module spi_pinctl_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic       wdata_bit0,
    input logic       master,
    input logic       single_wire,
    input logic       wait_stop,
    input logic       wait_i,
    input logic       busy,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       xfer_done,
    input logic       mode_fault
);
    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd1 && master && (wdata_bit0 != single_wire))
        |=> (!busy && !sck_o && !$rose(xfer_done)));

    // R9
    wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (master && wait_stop && wait_i && busy && !bus_we) |=> $stable(sck_o));

    // R10
    fault_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault) |-> (!sck_oe && !mosi_oe && !busy));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done) |-> !busy);

    // R6
    slave_sck_chk: assert property (@(posedge clk) disable iff (rst)
        !master |-> !sck_oe);
endmodule

bind spi_pinctl_unit spi_pinctl_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wdata_bit0  (bus_wdata[0]),
    .master      (mode_q.master),
    .single_wire (pin_q.single_wire),
    .wait_stop   (pin_q.wait_stop),
    .wait_i      (wait_i),
    .busy        (busy),
    .sck_o       (sck_o),
    .sck_oe      (sck_oe),
    .mosi_oe     (mosi_oe),
    .xfer_done   (xfer_done),
    .mode_fault  (mode_fault)
);

// File: tb/spi_pinctl_unit_bench.sv
module spi_pinctl_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wait_i = 1'b0;
    logic       sck_i, sck_o, sck_oe;
    logic       mosi_i, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ss_i, ss_o, ss_oe;
    logic       busy, xfer_done, mode_fault;
    logic       tb_sck = 1'b0;
    logic       tb_mosi = 1'b0;
    logic       tb_ss = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign sck_i  = sck_oe  ? sck_o  : tb_sck;
    assign mosi_i = mosi_oe ? mosi_o : tb_mosi;
    assign miso_i = miso_oe ? miso_o : mosi_o;
    assign ss_i   = ss_oe   ? ss_o   : tb_ss;

    spi_pinctl_unit u_spi_pinctl_unit (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_i(wait_i),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe),
        .busy(busy), .xfer_done(xfer_done), .mode_fault(mode_fault)
    );

    // pin, mode, tx, driven MOSI level, expected rx
    localparam logic [32:0] VECS [6] = '{
        {8'h00, 8'h03, 8'hA5, 1'b0, 8'hA5},
        {8'h00, 8'h03, 8'h3C, 1'b0, 8'h3C},
        {8'h09, 8'h03, 8'h96, 1'b0, 8'h96},
        {8'h01, 8'h03, 8'h12, 1'b1, 8'hFF},
        {8'h01, 8'h03, 8'h7E, 1'b0, 8'h00},
        {8'h10, 8'h07, 8'hC3, 1'b0, 8'hC3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            if (xfer_done) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] cap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd(2'd0, r); check("R2 mode reg", r, 8'h00);
        rd(2'd1, r); check("R2 pin reg", r, 8'h00);
        rd(2'd2, r); check("R2 data reg", r, 8'h00);
        check("R2 enables", {4'h0, sck_oe, mosi_oe, miso_oe, ss_oe}, 8'h00);
        check("R2 flags", {6'h0, xfer_done, mode_fault}, 8'h00);

        // R1 reserved bits
        wr(2'd1, 8'hFF);
        rd(2'd1, r); check("R1 pin reserved", r, 8'h1B);
        wr(2'd0, 8'hFF);
        rd(2'd0, r); check("R1 mode reg", r, 8'h07);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);

        // R3 R4 R5 vector walk
        foreach (VECS[k]) begin
            logic [32:0] v;
            v = VECS[k];
            wr(2'd0, 8'h00);
            wr(2'd1, v[32:25]);
            wr(2'd0, v[24:17]);
            tb_mosi = v[8];
            wr(2'd2, v[16:9]);
            check("R3 busy after start", {7'h0, busy}, 8'h01);
            check("R4 mosi enable", {7'h0, mosi_oe}, {7'h0, v[25] ? v[28] : 1'b1});
            check("R4 miso undriven", {7'h0, miso_oe}, 8'h00);
            if (v[19]) check("R5 ss low in transfer", {6'h0, ss_oe, ss_o}, 8'h02);
            wait_done();
            @(negedge clk);
            check("R3 done", {6'h0, xfer_done, busy}, 8'h02);
            rd(2'd2, r); check("R3 R4 rx byte", r, v[7:0]);
            if (v[19]) check("R5 ss high idle", {6'h0, ss_oe, ss_o}, 8'h03);
        end

        // R11 data write clears done
        wr(2'd2, 8'h55);
        check("R11 done cleared", {7'h0, xfer_done}, 8'h00);
        wait_done();

        // R5 fault-detect off: pin released, low SS ignored
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h07);
        check("R5 ss released", {7'h0, ss_oe}, 8'h00);
        tb_ss = 1'b0;
        idle(5);
        check("R10 no fault when disabled", {7'h0, mode_fault}, 8'h00);
        tb_ss = 1'b1;
        idle(3);

        // R8 abort on single-wire change
        wr(2'd0, 8'h03);
        wr(2'd2, 8'hFF);
        idle(6);
        check("R8 busy before abort", {7'h0, busy}, 8'h01);
        wr(2'd1, 8'h01);
        check("R8 abort spc", {5'h0, busy, sck_o, xfer_done}, 8'h00);
        // R8 abort on output-enable change in single-wire mode
        wr(2'd2, 8'hF0);
        idle(6);
        wr(2'd1, 8'h09);
        check("R8 abort wire oe", {5'h0, busy, sck_o, xfer_done}, 8'h00);
        // R8 abort on fault-detect change
        wr(2'd2, 8'h0F);
        idle(6);
        wr(2'd1, 8'h19);
        check("R8 abort fault_en", {5'h0, busy, sck_o, xfer_done}, 8'h00);
        // R8 output-enable change in normal mode has no effect
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h81);
        idle(6);
        wr(2'd1, 8'h08);
        check("R8 no abort", {7'h0, busy}, 8'h01);
        wait_done();
        @(negedge clk);
        rd(2'd2, r); check("R8 transfer completes", r, 8'h81);

        // R9 wait stop
        wr(2'd1, 8'h02);
        wait_i = 1'b1;
        wr(2'd2, 8'h6B);
        idle(60);
        check("R9 frozen", {6'h0, busy, xfer_done}, 8'h02);
        wait_i = 1'b0;
        wait_done();
        @(negedge clk);
        check("R9 resumes", {6'h0, busy, xfer_done}, 8'h01);
        wr(2'd1, 8'h00);
        wait_i = 1'b1;
        wr(2'd2, 8'h6C);
        wait_done();
        @(negedge clk);
        rd(2'd2, r); check("R9 wait ignored", r, 8'h6C);
        wait_i = 1'b0;

        // R10 mode fault
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'hAA);
        idle(4);
        tb_ss = 1'b0;
        idle(5);
        check("R10 fault set", {7'h0, mode_fault}, 8'h01);
        rd(2'd0, r); check("R10 master cleared", r, 8'h01);
        check("R10 released", {4'h0, sck_oe, mosi_oe, busy, xfer_done}, 8'h00);
        tb_ss = 1'b1;
        idle(5);
        check("R10 sticky", {7'h0, mode_fault}, 8'h01);
        wr(2'd0, 8'h03);
        check("R10 cleared by write", {7'h0, mode_fault}, 8'h00);

        // R6 slave pin roles
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h05);
        check("R6 slave drives none", {4'h0, sck_oe, mosi_oe, miso_oe, ss_oe}, 8'h00);
        tb_ss = 1'b0;
        idle(4);
        check("R6 miso when selected", {4'h0, sck_oe, mosi_oe, miso_oe, ss_oe}, 8'h02);
        wr(2'd1, 8'h01);
        check("R6 single-wire oe off", {7'h0, miso_oe}, 8'h00);
        wr(2'd1, 8'h09);
        check("R6 single-wire oe on", {7'h0, miso_oe}, 8'h01);
        tb_ss = 1'b1;
        wr(2'd1, 8'h00);
        idle(4);

        // R7 slave transfer
        wr(2'd0, 8'h01);
        wr(2'd2, 8'hA5);
        tb_ss = 1'b0;
        idle(4);
        cap = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            tb_mosi = 8'h3C >> b;
            idle(4);
            cap = {cap[6:0], miso_o};
            tb_sck = 1'b1;
            idle(4);
            tb_sck = 1'b0;
        end
        idle(6);
        check("R7 slave done", {7'h0, xfer_done}, 8'h01);
        rd(2'd2, r); check("R7 slave rx", r, 8'h3C);
        check("R7 slave tx on miso", cap, 8'hA5);
        tb_ss = 1'b1;
        idle(2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule